// File: doc/BRIEF.md
# Store Instruction Decoder

This block looks at one 32-bit RISC-V instruction word per cycle and decides whether it belongs to the store class. For a store it returns the base and data register indexes, an access size code, and the byte offset. The offset is rebuilt from two separate immediate fields in the word and then sign-extended to the offset width. Every result is registered, so the decoded word appears one cycle after the input word.

The store width comes only from the 3-bit minor opcode field, because all store widths share one major opcode. A word whose major opcode is not the store opcode is reported as illegal. So is a word that carries an unsupported minor code. A parameter can remove doubleword support, and the 011 code is then illegal too. The register-index, size and offset outputs are captured on every valid input, legal or not, and hold while the input is idle.

Top module: `stdec_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_vld`, `out_store` and `out_illegal` are 0 after that edge, and `out_rs1`, `out_rs2`, `out_size` and `out_offset` are 0.
- R2: `out_vld` after a clock edge equals `in_vld` at that edge, so the latency is one cycle.
- R3: A valid word with bits [6:0] = 0100011 and bits [14:12] in {000, 001, 010, 011} gives `out_store` = 1 and `out_illegal` = 0 one cycle later. The 011 code counts here only when `EN_DWORD` = 1.
- R4: `out_size` equals bits [13:12] of the captured word. The codes are 0 for byte (000), 1 for halfword (001), 2 for word (010) and 3 for doubleword (011).
- R5: `out_offset` is the two's-complement sign extension to `OFS_W` bits of the 12-bit value {bits [31:25], bits [11:7]}. Bits [31:25] are the upper seven offset bits.
- R6: `out_rs1` equals bits [19:15] of the captured word and `out_rs2` equals bits [24:20].
- R7: A valid word whose bit 14 is 1 (minor codes 100 to 111) gives `out_illegal` = 1 and `out_store` = 0 one cycle later.
- R8: A valid word whose bits [6:0] differ from 0100011 gives `out_illegal` = 1 and `out_store` = 0 one cycle later, whatever its minor code.
- R9: With `EN_DWORD` = 0, a valid store-opcode word with minor code 011 gives `out_illegal` = 1 and `out_store` = 0.
- R10: When `in_vld` is 0 at an edge, `out_store` and `out_illegal` become 0, and `out_rs1`, `out_rs2`, `out_size` and `out_offset` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Instruction word present |
| in_insn | input | 32 | Instruction word |
| out_vld | output | 1 | Decoded result present (one cycle after `in_vld`) |
| out_store | output | 1 | Word is a supported store |
| out_illegal | output | 1 | Word is not a supported store |
| out_rs1 | output | 5 | Base register index |
| out_rs2 | output | 5 | Data register index |
| out_size | output | 2 | Access size code (log2 of bytes) |
| out_offset | output | OFS_W | Sign-extended byte offset |

## Verification
The offset rebuild and the legality verdict are worked out from the same word in the same cycle. A bad minor code or a foreign major opcode must not disturb the offset, the register indexes or the size that are captured alongside it. To test this, the bench crosses every one of the 4096 immediate values with all eight minor codes under the store opcode, and adds a set of foreign opcodes. It then checks each output against values computed arithmetically. A second instance, built without doubleword support, takes the same words, and only its verdict on code 011 may differ.

// File: rtl/stdec_pkg.sv
// Shared constants and types for the store decoder.
// Assumes the 32-bit base instruction encoding (no compressed words).
package stdec_pkg;
    localparam int          INSN_W    = 32;
    localparam int          REG_W     = 5;
    localparam int          IMM_W     = 12;
    localparam logic [6:0]  OPC_STORE = 7'b0100011;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } size_e;

    typedef struct packed {
        logic [IMM_W-1:0] imm;
        logic [REG_W-1:0] rs2;
        logic [REG_W-1:0] rs1;
        logic [2:0]       minor;
        logic [6:0]       major;
    } fields_t;
endpackage

// File: rtl/stdec_split.sv
// Splits a store-format word into its fields and joins the two
// immediate pieces into one 12-bit value. Purely combinational.
// Assumes the register and opcode fields sit at the fixed positions
// shared with the other formats.
module stdec_split
    import stdec_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output fields_t           flds
);
    // Pick out fields; upper immediate piece goes above the lower one.
    always_comb begin
        flds.major = insn[6:0];
        flds.minor = insn[14:12];
        flds.rs1   = insn[19:15];
        flds.rs2   = insn[24:20];
        flds.imm   = {insn[31:25], insn[11:7]};
    end
endmodule

// File: rtl/stdec_class.sv
// Decides whether a word is a supported store and gives its size code.
// Combinational. EN_DWORD selects whether minor code 011 is accepted.
module stdec_class
    import stdec_pkg::*;
#(
    parameter bit EN_DWORD = 1'b1
)(
    input  logic [6:0] major,
    input  logic [2:0] minor,
    output logic       is_store,
    output size_e      size
);
    logic minor_ok;

    generate
        if (EN_DWORD) begin : g_dw
            // Codes 000..011 are all legal widths.
            always_comb minor_ok = ~minor[2];
        end else begin : g_nodw
            // Codes 000..010 only; 011 is rejected.
            always_comb minor_ok = ~minor[2] && (minor[1:0] != 2'b11);
        end
    endgenerate

    // Store only when the major opcode matches and the width is supported.
    always_comb begin
        is_store = (major == OPC_STORE) && minor_ok;
        size     = size_e'(minor[1:0]);
    end
endmodule

// File: rtl/stdec_sext.sv
// Sign-extends a 12-bit offset to OFS_W bits. Assumes OFS_W > 12.
module stdec_sext
    import stdec_pkg::*;
#(
    parameter int OFS_W = 32
)(
    input  logic [IMM_W-1:0] imm,
    output logic [OFS_W-1:0] ofs
);
    localparam int EXT_W = OFS_W - IMM_W;

    // Replicate the top immediate bit into the upper part.
    always_comb ofs = {{EXT_W{imm[IMM_W-1]}}, imm};
endmodule

// File: rtl/stdec_top.sv
// Store decoder top: splits, classifies and sign-extends one word per
// cycle and registers the result. Synchronous active-low reset.
// The field outputs are captured on any valid word and held otherwise.
module stdec_top
    import stdec_pkg::*;
#(
    parameter bit EN_DWORD = 1'b1,
    parameter int OFS_W    = 32
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [31:0]       in_insn,
    output logic              out_vld,
    output logic              out_store,
    output logic              out_illegal,
    output logic [4:0]        out_rs1,
    output logic [4:0]        out_rs2,
    output logic [1:0]        out_size,
    output logic [OFS_W-1:0]  out_offset
);
    fields_t          flds;
    logic             is_store;
    size_e            size;
    logic [OFS_W-1:0] ofs;

    stdec_split u_split (.insn(in_insn), .flds(flds));

    stdec_class #(.EN_DWORD(EN_DWORD)) u_class (
        .major(flds.major), .minor(flds.minor),
        .is_store(is_store), .size(size)
    );

    stdec_sext #(.OFS_W(OFS_W)) u_sext (.imm(flds.imm), .ofs(ofs));

    // Output register: verdict every cycle, fields only on valid words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld     <= 1'b0;
            out_store   <= 1'b0;
            out_illegal <= 1'b0;
            out_rs1     <= '0;
            out_rs2     <= '0;
            out_size    <= '0;
            out_offset  <= '0;
        end else begin
            out_vld     <= in_vld;
            out_store   <= in_vld && is_store;
            out_illegal <= in_vld && !is_store;
            if (in_vld) begin
                out_rs1    <= flds.rs1;
                out_rs2    <= flds.rs2;
                out_size   <= size;
                out_offset <= ofs;
            end
        end
    end

    // R2: valid follows the input by one cycle
    a_r2_vld_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    a_r2_idle_latency: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
    // R3: store opcode with a low minor code is accepted
    a_r3_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_insn[6:0] == 7'b0100011 && !in_insn[14]
         && (EN_DWORD || in_insn[13:12] != 2'b11))
        |=> (out_store && !out_illegal));
    // R5: low 12 offset bits are the joined immediate pieces
    a_r5_offset: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (out_offset[11:0] == {$past(in_insn[31:25]), $past(in_insn[11:7])}
                    && out_offset[OFS_W-1] == $past(in_insn[31])));
    // R7: upper minor codes are illegal
    a_r7_high_minor: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_insn[14]) |=> (out_illegal && !out_store));
    // R8: foreign major opcode is illegal
    a_r8_foreign_major: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_insn[6:0] != 7'b0100011) |=> (out_illegal && !out_store));
    // R10: idle cycles hold the fields and clear the verdict
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(out_offset) && $stable(out_rs1) && $stable(out_rs2)
                     && $stable(out_size) && !out_store && !out_illegal));

    generate
        if (!EN_DWORD) begin : g_chk_nodw
            // R9: doubleword code rejected when support is off
            a_r9_no_dword: assert property (@(posedge clk) disable iff (!rst_n)
                (in_vld && in_insn[14:12] == 3'b011) |=> (out_illegal && !out_store));
        end
    endgenerate
endmodule

// File: tb/sim_stdec_top.sv
module sim_stdec_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [31:0] in_insn = '0;

    logic        o_vld, o_st, o_ill;
    logic [4:0]  o_rs1, o_rs2;
    logic [1:0]  o_sz;
    logic [31:0] o_ofs;
    logic        n_vld, n_st, n_ill;
    logic [4:0]  n_rs1, n_rs2;
    logic [1:0]  n_sz;
    logic [31:0] n_ofs;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    stdec_top #(.EN_DWORD(1'b1), .OFS_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_insn(in_insn),
        .out_vld(o_vld), .out_store(o_st), .out_illegal(o_ill),
        .out_rs1(o_rs1), .out_rs2(o_rs2), .out_size(o_sz), .out_offset(o_ofs));

    stdec_top #(.EN_DWORD(1'b0), .OFS_W(32)) u1 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_insn(in_insn),
        .out_vld(n_vld), .out_store(n_st), .out_illegal(n_ill),
        .out_rs1(n_rs1), .out_rs2(n_rs2), .out_size(n_sz), .out_offset(n_ofs));

    task automatic check(input string tag, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (insn %h)", tag, act, exp, in_insn);
        end
    endtask

    function automatic logic [31:0] mk(input int imm, input int rs2, input int rs1,
                                       input int f3, input logic [6:0] opc);
        logic [11:0] i12 = imm[11:0];
        return {i12[11:5], rs2[4:0], rs1[4:0], f3[2:0], i12[4:0], opc};
    endfunction

    // Drive at a falling edge, sample at the next falling edge.
    task automatic apply(input logic v, input logic [31:0] w);
        in_vld  = v;
        in_insn = w;
        @(negedge clk);
    endtask

    task automatic check_word(input int imm, input int rs2, input int rs1,
                              input int f3, input logic [6:0] opc);
        int  exp_ofs;
        bit  st_a, st_b;
        exp_ofs = (imm >= 2048) ? imm - 4096 : imm;
        st_a = (opc == 7'b0100011) && (f3 < 4);
        st_b = (opc == 7'b0100011) && (f3 < 3);
        check("R2 vld", o_vld, 1);
        check(opc == 7'b0100011 ? (f3 < 4 ? "R3 store" : "R7 store") : "R8 store", o_st, st_a);
        check(opc == 7'b0100011 ? (f3 < 4 ? "R3 illegal" : "R7 illegal") : "R8 illegal", o_ill, !st_a);
        check("R4 size", o_sz, f3 % 4);
        check("R5 offset", $signed(o_ofs), exp_ofs);
        check("R6 rs1", o_rs1, rs1);
        check("R6 rs2", o_rs2, rs2);
        check("R9 store", n_st, st_b);
        check("R9 illegal", n_ill, !st_b);
    endtask

    initial begin
        logic [6:0] foreign [3];
        foreign[0] = 7'b0000011;
        foreign[1] = 7'b0100111;
        foreign[2] = 7'b1100011;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 vld", o_vld, 0);
        check("R1 store", o_st, 0);
        check("R1 illegal", o_ill, 0);
        check("R1 offset", o_ofs, 0);
        check("R1 rs1", o_rs1, 0);
        rst_n = 1'b1;

        // Full immediate sweep crossed with every minor code, store opcode.
        for (int i = 0; i < 4096; i++) begin
            for (int f = 0; f < 8; f++) begin
                int r1 = (i + f) % 32;
                int r2 = (i * 7 + f * 3) % 32;
                apply(1'b1, mk(i, r2, r1, f, 7'b0100011));
                check_word(i, r2, r1, f, 7'b0100011);
            end
        end

        // Foreign major opcodes: fields still decoded, verdict illegal.
        for (int o = 0; o < 3; o++) begin
            for (int f = 0; f < 8; f++) begin
                for (int k = 0; k < 16; k++) begin
                    int imm = (k * 263 + 2040) % 4096;
                    apply(1'b1, mk(imm, k, 31 - k, f, foreign[o]));
                    check_word(imm, k, 31 - k, f, foreign[o]);
                end
            end
        end

        // R10 / R2: idle cycle holds fields, clears verdict.
        apply(1'b1, mk(12'h801, 9, 17, 2, 7'b0100011));
        check_word(12'h801, 9, 17, 2, 7'b0100011);
        apply(1'b0, mk(12'h7ff, 3, 4, 6, 7'b0110011));
        check("R2 idle vld", o_vld, 0);
        check("R10 store", o_st, 0);
        check("R10 illegal", o_ill, 0);
        check("R10 offset", $signed(o_ofs), -2047);
        check("R10 rs1", o_rs1, 17);
        check("R10 rs2", o_rs2, 9);
        check("R10 size", o_sz, 2);

        // R1: reset mid-run clears everything.
        rst_n = 1'b0;
        apply(1'b1, mk(12'hfff, 1, 2, 0, 7'b0100011));
        check("R1 vld mid", o_vld, 0);
        check("R1 store mid", o_st, 0);
        check("R1 offset mid", o_ofs, 0);
        rst_n = 1'b1;
        apply(1'b0, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule